// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block watches one already-demodulated infrared receiver line and turns it into a stream of run-length symbols. A free-running divider makes one sample strobe every `DIV` clock cycles. For example, 64 cycles of an 8 MHz clock give 8 µs per sample. On each strobe the line level is sampled after a two-flop synchronizer and an optional inversion. The encoder measures how many samples the line stays at one level and reports each run as one 8-bit symbol. Bit 7 of the symbol is the level, where 1 means an active mark. Bits 6:0 hold the run length in samples minus one.

Short excursions are treated as noise, and a configurable threshold sets how many samples that covers. A noise excursion is counted into the run that surrounds it. A long period of inactive line closes the packet: the pending space run is flushed, a one-cycle packet-end pulse is raised, and the encoder then stays silent until the next genuine mark. A typical setup uses a noise threshold of 1 and an idle threshold of 20. The block runs only while two enable inputs are both high and the mode input selects the carrier-free receive mode. Removing any of these conditions clears all counting state.

Top module: `ir_runlen_enc`

## Requirements
- R1: The block runs only when `glob_en` and `rx_en` are both 1 and `mode` is 2'b11. Otherwise `sym_valid` and `pkt_end` stay 0, and the divider and all run state are cleared, so a run that was in progress is never reported.
- R2: One line sample is taken every `DIV` clock cycles while running, and run lengths are counted in these samples.
- R3: A symbol is presented on `sym_data` for one cycle with `sym_valid` = 1. `sym_data[7]` is the run level (1 = mark) and `sym_data[6:0]` is the run length in samples minus one.
- R4: When `rx_invert` = 1 the line is inverted before sampling, so a low input counts as a mark.
- R5: A level change lasting no more than `noise_thr` samples does not end the current run, and those samples are added to that run's length.
- R6: A level change lasting more than `noise_thr` samples ends the current run. The new run's length includes every sample from its first changed sample. With `noise_thr` = 0, a single sample is enough.
- R7: A run of more than 128 samples is reported as symbols with length field 0x7F for each full 128 samples, followed by one symbol for the remainder.
- R8: When a space inside a packet becomes longer than `idle_thr` × 128 samples, one symbol of level 0 is emitted with its length clipped to 128. `pkt_end` is 1 in that same cycle only. A space of exactly `idle_thr` × 128 samples does not end the packet.
- R9: Outside a packet no symbols are produced. Space before the first mark is not reported, and a noise excursion while idle does not start a packet.
- R10: After reset `sym_valid`, `sym_data` and `pkt_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode, 2'b11 selects carrier-free receive |
| rx_invert | input | 1 | Invert the line before sampling |
| noise_thr | input | NOISE_W (6) | Longest excursion in samples treated as noise |
| idle_thr | input | IDLE_W (8) | Packet-end threshold in units of 128 samples |
| ir_in | input | 1 | Demodulated receiver line, asynchronous |
| sym_valid | output | 1 | Symbol strobe |
| sym_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | One-cycle packet-end pulse, coincides with the flush symbol |

## Verification
The bench builds the encoder with `DIV` = 4, so one sample lasts four clocks. This keeps multi-packet scenarios short enough to sweep noise thresholds 0, 1 and 3 and idle thresholds 1 and 2. It also reaches runs of several hundred samples, which cross the 128-sample split, and spaces of exactly 128 and 129 samples that sit on either side of the idle boundary. Every expected symbol is derived from the driven run lengths by arithmetic splitting into 128-sample pieces.

// File: rtl/ir_enc_pkg.sv
package ir_enc_pkg;

    // Width of the length field in a symbol; runs split at 2**SYM_LEN_W samples
    localparam int SYM_LEN_W = 7;

    // Mode code that selects carrier-free receive
    localparam logic [1:0] MODE_RX_RAW = 2'b11;

    typedef enum logic {
        LINE_SPACE = 1'b0,
        LINE_MARK  = 1'b1
    } line_lvl_e;

    typedef struct packed {
        logic                 mark;
        logic [SYM_LEN_W-1:0] len_m1;
    } ir_sym_t;

    // Build a symbol from a level and a run length (1 .. 2**SYM_LEN_W)
    function automatic ir_sym_t pack_sym(logic mark, logic [SYM_LEN_W:0] len);
        logic [SYM_LEN_W:0] t;
        ir_sym_t s;
        t        = len - 1'b1;
        s.mark   = mark;
        s.len_m1 = t[SYM_LEN_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick) else $error("back-to-back sample strobes"); // R2

endmodule

// File: rtl/ir_in_cond.sv
module ir_in_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ir_in,
    input  logic invert,
    output logic sample
);
    logic [SYNC_STAGES-1:0] sh;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= ir_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[SYNC_STAGES-2:0], ir_in};
            end
        end
    endgenerate

    assign sample = sh[SYNC_STAGES-1] ^ invert;

endmodule

// File: rtl/ir_run_packer.sv
module ir_run_packer
    import ir_enc_pkg::*;
#(
    parameter int NOISE_W = 6,
    parameter int IDLE_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tick,
    input  logic               sample,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    output logic               sym_valid,
    output ir_sym_t            sym,
    output logic               pkt_end
);
    localparam int CW = SYM_LEN_W + 2;
    localparam int IW = IDLE_W + SYM_LEN_W + 1;
    localparam logic [CW-1:0]        RUN_MAX   = CW'(2 ** SYM_LEN_W);
    localparam logic [SYM_LEN_W:0]   RUN_MAX_S = (SYM_LEN_W + 1)'(2 ** SYM_LEN_W);

    typedef struct packed {
        line_lvl_e          lvl;
        logic               in_pkt;
        logic [CW-1:0]      run_len;
        logic [NOISE_W-1:0] dev;
        logic [IW-1:0]      idle;
    } pk_state_t;

    pk_state_t q, d;
    logic      emit, end_d;
    ir_sym_t   emit_sym;
    logic [CW-1:0] grow;
    logic [IW-1:0] idle_grow, idle_limit;
    line_lvl_e new_lvl;

    assign idle_limit = {1'b0, idle_thr, {SYM_LEN_W{1'b0}}};

    always_comb begin
        d         = q;
        emit      = 1'b0;
        end_d     = 1'b0;
        emit_sym  = '0;
        grow      = q.run_len + CW'(q.dev) + CW'(1);
        idle_grow = q.idle + IW'(q.dev) + IW'(1);
        new_lvl   = line_lvl_e'(sample);
        if (tick) begin
            if (new_lvl == q.lvl) begin
                d.dev = '0;
                if (q.in_pkt) begin
                    if (q.lvl == LINE_SPACE && idle_grow > idle_limit) begin
                        emit     = 1'b1;
                        end_d    = 1'b1;
                        emit_sym = pack_sym(1'b0, (grow > RUN_MAX) ? RUN_MAX_S
                                                                   : grow[SYM_LEN_W:0]);
                        d.in_pkt  = 1'b0;
                        d.run_len = '0;
                        d.idle    = '0;
                    end else begin
                        if (grow > RUN_MAX) begin
                            emit      = 1'b1;
                            emit_sym  = pack_sym(q.lvl == LINE_MARK, RUN_MAX_S);
                            d.run_len = grow - RUN_MAX;
                        end else begin
                            d.run_len = grow;
                        end
                        if (q.lvl == LINE_SPACE) d.idle = idle_grow;
                    end
                end
            end else if (q.dev == noise_thr) begin
                d.lvl     = new_lvl;
                d.dev     = '0;
                d.run_len = CW'(q.dev) + CW'(1);
                d.idle    = (new_lvl == LINE_SPACE) ? IW'(q.dev) + IW'(1) : '0;
                if (q.in_pkt) begin
                    emit     = 1'b1;
                    emit_sym = pack_sym(q.lvl == LINE_MARK, q.run_len[SYM_LEN_W:0]);
                end else if (new_lvl == LINE_SPACE) begin
                    d.run_len = '0;
                    d.idle    = '0;
                end else begin
                    d.in_pkt = 1'b1;
                end
            end else begin
                d.dev = q.dev + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            q         <= '0;
            sym_valid <= 1'b0;
            sym       <= '0;
            pkt_end   <= 1'b0;
        end else begin
            q         <= d;
            sym_valid <= emit;
            sym       <= emit_sym;
            pkt_end   <= end_d;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        q.run_len <= RUN_MAX) else $error("run counter beyond split point"); // R7
    AST_END_IS_SPACE: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> (sym_valid && !sym.mark)) else $error("packet end without space symbol"); // R8
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> !pkt_end) else $error("packet end wider than one cycle"); // R8

endmodule

// File: rtl/ir_runlen_enc.sv
module ir_runlen_enc
    import ir_enc_pkg::*;
#(
    parameter int DIV         = 64,
    parameter int NOISE_W     = 6,
    parameter int IDLE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               glob_en,
    input  logic               rx_en,
    input  logic [1:0]         mode,
    input  logic               rx_invert,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    input  logic               ir_in,
    output logic               sym_valid,
    output logic [SYM_LEN_W:0] sym_data,
    output logic               pkt_end
);
    logic    run, tick, sample;
    ir_sym_t sym;

    assign run = glob_en && rx_en && (mode == MODE_RX_RAW);

    ir_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    ir_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .ir_in  (ir_in),
        .invert (rx_invert),
        .sample (sample)
    );

    ir_run_packer #(.NOISE_W(NOISE_W), .IDLE_W(IDLE_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tick      (tick),
        .sample    (sample),
        .noise_thr (noise_thr),
        .idle_thr  (idle_thr),
        .sym_valid (sym_valid),
        .sym       (sym),
        .pkt_end   (pkt_end)
    );

    assign sym_data = sym;

    AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!sym_valid && !pkt_end)) else $error("output while stopped"); // R1
    AST_SYM_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $past(tick)) else $error("symbol without sample strobe"); // R2

endmodule

// File: tb/ir_runlen_enc_tb.sv
module ir_runlen_enc_tb;
    localparam int DIV_T = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       glob_en = 1'b0, rx_en = 1'b0, rx_invert = 1'b0, ir_in = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd1;
    logic       sym_valid, pkt_end;
    logic [7:0] sym_data;

    int  checks = 0, errors = 0;
    bit  done = 0;
    bit  drv_inv = 0;
    logic [9:0] got [0:255];
    logic [9:0] expq [0:255];
    int  n_got = 0, n_exp = 0, base = 0;

    always #2 clk = ~clk;

    ir_runlen_enc #(.DIV(DIV_T)) u_dut (
        .clk(clk), .rst(rst), .glob_en(glob_en), .rx_en(rx_en), .mode(mode),
        .rx_invert(rx_invert), .noise_thr(noise_thr), .idle_thr(idle_thr),
        .ir_in(ir_in), .sym_valid(sym_valid), .sym_data(sym_data), .pkt_end(pkt_end)
    );

    always @(negedge clk) begin
        if (sym_valid || pkt_end) begin
            if (n_got < 256) got[n_got] = {pkt_end, sym_valid, sym_data};
            n_got = n_got + 1;
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(bit lvl, int n);
        ir_in = lvl ^ drv_inv;
        repeat (n * DIV_T) @(negedge clk);
    endtask

    task automatic push(bit e, bit lvl, int code);
        expq[n_exp] = {e, 1'b1, lvl, code[6:0]};
        n_exp++;
    endtask

    // run of n samples split into 128-sample pieces (R7)
    task automatic add_run(bit lvl, int n);
        int r = n;
        while (r > 128) begin
            push(1'b0, lvl, 127);
            r -= 128;
        end
        push(1'b0, lvl, r - 1);
    endtask

    // trailing space closing a packet with idle threshold t (R8)
    task automatic add_idle(int t);
        for (int k = 0; k < t - 1; k++) push(1'b0, 1'b0, 127);
        push(1'b1, 1'b0, 127);
    endtask

    task automatic begin_case(int nthr, int ithr, bit inv);
        @(negedge clk);
        noise_thr = 6'(nthr);
        idle_thr  = 8'(ithr);
        rx_invert = inv;
        drv_inv   = inv;
        ir_in     = inv;
        mode      = 2'b11;
        rx_en     = 1'b1;
        glob_en   = 1'b1;
        base      = n_got;
        n_exp     = 0;
    endtask

    task automatic end_case(string tag);
        glob_en = 1'b0;
        repeat (3) @(negedge clk);
        check(n_got - base == n_exp, tag, "symbol count", n_got - base, n_exp);
        for (int i = 0; i < n_exp; i++)
            if (i < n_got - base)
                check(got[base + i] == expq[i], tag, "symbol {end,valid,data}",
                      int'(got[base + i]), int'(expq[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: outputs quiet during and after reset
        check(sym_valid == 1'b0, "R10", "sym_valid in reset", int'(sym_valid), 0);
        check(sym_data == 8'h00, "R10", "sym_data in reset", int'(sym_data), 0);
        check(pkt_end == 1'b0, "R10", "pkt_end in reset", int'(pkt_end), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sym_valid == 1'b0 && pkt_end == 1'b0, "R10", "outputs after reset",
              int'({sym_valid, pkt_end}), 0);

        // R1: wrong mode, then missing global enable -> nothing
        begin_case(1, 1, 0);
        mode = 2'b01;
        drive(0, 5); drive(1, 10); drive(0, 5); drive(1, 10); drive(0, 150);
        mode = 2'b11; glob_en = 1'b0;
        drive(1, 10); drive(0, 150);
        glob_en = 1'b1; rx_en = 1'b0;
        drive(1, 10); drive(0, 150);
        end_case("R1");

        // R2 R3 R8 R9: basic packet, then idle glitch, then second packet
        begin_case(1, 1, 0);
        drive(0, 20); drive(1, 10); drive(0, 5); drive(1, 3); drive(0, 140);
        drive(1, 1); drive(0, 20); drive(1, 6); drive(0, 140);
        add_run(1, 10); add_run(0, 5); add_run(1, 3); add_idle(1);
        add_run(1, 6); add_idle(1);
        end_case("R2 R3 R8 R9");

        // R5 R6: noise threshold 1, glitches absorbed or splitting
        begin_case(1, 1, 0);
        drive(0, 4); drive(1, 10); drive(0, 1); drive(1, 10); drive(0, 2); drive(1, 4);
        drive(0, 6); drive(1, 1); drive(0, 6); drive(1, 5); drive(0, 140);
        add_run(1, 21); add_run(0, 2); add_run(1, 4); add_run(0, 13); add_run(1, 5);
        add_idle(1);
        end_case("R5 R6 thr1");

        // R6: noise threshold 0, single-sample runs kept
        begin_case(0, 1, 0);
        drive(0, 3); drive(1, 1); drive(0, 1); drive(1, 2); drive(0, 140);
        add_run(1, 1); add_run(0, 1); add_run(1, 2); add_idle(1);
        end_case("R6 thr0");

        // R5 R6: noise threshold 3
        begin_case(3, 1, 0);
        drive(0, 4); drive(1, 10); drive(0, 3); drive(1, 10); drive(0, 4); drive(1, 5);
        drive(0, 140);
        add_run(1, 23); add_run(0, 4); add_run(1, 5); add_idle(1);
        end_case("R5 R6 thr3");

        // R7: long runs split, idle threshold 2
        begin_case(1, 2, 0);
        drive(0, 4); drive(1, 300); drive(0, 200); drive(1, 128); drive(0, 300);
        add_run(1, 300); add_run(0, 200); add_run(1, 128); add_idle(2);
        end_case("R7");

        // R4: inverted line
        begin_case(1, 1, 1);
        drive(0, 4); drive(1, 7); drive(0, 9); drive(1, 4); drive(0, 140);
        add_run(1, 7); add_run(0, 9); add_run(1, 4); add_idle(1);
        end_case("R4");

        // R8 R9: idle boundary 128 vs 129 space samples
        begin_case(1, 1, 0);
        drive(0, 4); drive(1, 3); drive(0, 128); drive(1, 3); drive(0, 129);
        drive(1, 3); drive(0, 140);
        add_run(1, 3); add_run(0, 128); add_run(1, 3); add_idle(1);
        add_run(1, 3); add_idle(1);
        end_case("R8 R9 boundary");

        // R1: disabling mid-run drops the run
        begin_case(1, 1, 0);
        drive(0, 4); drive(1, 20);
        end_case("R1 drop");
        begin_case(1, 1, 0);
        drive(0, 3); drive(1, 5); drive(0, 140);
        add_run(1, 5); add_idle(1);
        end_case("R1 restart");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule